// File: doc/BRIEF.md
# Dynamic Slow-Go Clock Rate Generator

This block derives the general system clock of a chip from a fast base clock. The output is not a new clock net but a one-cycle clock-enable pulse in the base domain. With no extra division the enable fires every second base cycle, which is the normal rate. Two three-bit divider fields set a low rate and a high rate. Each field stretches the period by a power of four.

Software sets a source-control bit to enter low-power operation, and the block then runs at the low rate. While an interrupt is pending above the current mask, or while the communication co-processor is busy with its request-enable set, the block raises itself to the high rate. When that activity ends it drops back to the low rate. A new rate is only adopted when the current output period has finished, so no period is ever shortened. A twice-rate companion enable accompanies the main enable. A separate slow-peripheral enable is produced either every base cycle or every 128th cycle, chosen by a two-bit mode input.

Top module: `slowgo_clkgen`

## Requirements
- R1: During reset `gclk_en` is 0 and `spclk_en` is 0 with `spclk_mode` = 2'b01. After reset the `gclk_en` period is 2 base cycles.
- R2: While `src_ctl` = 0 the `gclk_en` period is 2 cycles, whatever the divider fields, the interrupt inputs and the co-processor inputs are.
- R3: With `src_ctl` = 1 and no wake condition, the period is 2·4^`div_low` cycles (`div_low` = 1 gives 8, 2 gives 32, 3 gives 128).
- R4: A pending interrupt wakes the block only when `irq_level` > `irq_mask` (strict, unsigned). It then runs at 2·4^`div_high`. When the level equals the mask, the low rate stays in force.
- R5: Co-processor activity wakes the block only when `cp_req_en` = 1 and `cp_busy` = 1 together. Either one alone leaves the low rate in force.
- R6: When a wake condition holds and `div_high` = 0, the period is 2 cycles (the normal rate).
- R7: `gclk2_en` pulses exactly twice per `gclk_en` period. One pulse falls in the same cycle as `gclk_en`. The other falls on the half-period cycle, which is `gclk2_en` in every cycle at the normal rate.
- R8: A change of the selecting inputs in mid-period does not alter the period in progress. The new rate starts with the period after the next `gclk_en` pulse.
- R9: `spclk_mode` = 2'b01 makes `spclk_en` pulse once every 128 base cycles. Every other mode value makes `spclk_en` high in every cycle.
- R10: `gclk_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock (twice the normal system rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ctl | input | 1 | 1 allows low-power operation, 0 forces the normal rate |
| div_low | input | 3 | Low-rate divider exponent |
| div_high | input | 3 | High-rate divider exponent (0 means the normal rate) |
| irq_level | input | 3 | Level of the pending interrupt |
| irq_mask | input | 3 | Current interrupt mask level |
| cp_req_en | input | 1 | Co-processor wake request enable |
| cp_busy | input | 1 | Co-processor is not idle |
| spclk_mode | input | 2 | Slow-peripheral prescaler mode |
| gclk_en | output | 1 | General system clock enable pulse |
| gclk2_en | output | 1 | Twice-rate companion enable pulse |
| spclk_en | output | 1 | Slow-peripheral clock enable |

## Verification
The hardest situation to reach is a selection change that lands in the middle of a long period. It is the only case where adopting the new rate at once and adopting it at the boundary produce different outputs. The stimulus first runs the low rate until it is stable at 32 cycles per period and locks onto a `gclk_en` pulse. Five cycles later it drops `src_ctl`. The bench then checks that this period still lasts 32 cycles and that the next one lasts 2. The strict interrupt comparison and the co-processor condition that needs both inputs are reached by holding one input at its edge value while the other is toggled.

// File: rtl/slowgo_pkg.sv
package slowgo_pkg;

    // Which rate source is driving the period counter
    typedef enum logic [1:0] {
        SRC_NORMAL = 2'd0,
        SRC_LOW    = 2'd1,
        SRC_HIGH   = 2'd2
    } rate_src_e;

    // Prescaler mode that divides by 2**PRE_W; all others pass through
    localparam logic [1:0] SPMODE_DIVIDE = 2'b01;

endpackage

// File: rtl/slowgo_rate_sel.sv
module slowgo_rate_sel
    import slowgo_pkg::*;
#(
    parameter int DIV_W = 3,
    parameter int LVL_W = 3
) (
    input  logic             src_ctl,
    input  logic [DIV_W-1:0] div_low,
    input  logic [DIV_W-1:0] div_high,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] irq_mask,
    input  logic             cp_req_en,
    input  logic             cp_busy,
    output rate_src_e        rate_src,
    output logic [DIV_W-1:0] sel_div
);

    logic irq_wake;
    logic cp_wake;

    always_comb begin
        irq_wake = (irq_level > irq_mask);
        cp_wake  = cp_req_en && cp_busy;
        if (!src_ctl) begin
            rate_src = SRC_NORMAL;
            sel_div  = '0;
        end else if (irq_wake || cp_wake) begin
            // a zero high field falls back to the normal rate by itself
            rate_src = SRC_HIGH;
            sel_div  = div_high;
        end else begin
            rate_src = SRC_LOW;
            sel_div  = div_low;
        end
    end

endmodule

// File: rtl/slowgo_period_ctr.sv
module slowgo_period_ctr #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] sel_div,
    output logic             tick,
    output logic             tick2
);

    localparam int MAX_EXP = (1 << DIV_W) - 1;
    localparam int CNT_W   = 2 * MAX_EXP + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } ctr_t;

    ctr_t             st_d, st_q;
    logic [DIV_W:0]   shamt;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] half_cnt;

    always_comb begin
        shamt    = {st_q.div, 1'b0};
        last_cnt = (CNT_W'(2) << shamt) - CNT_W'(1);
        half_cnt = (CNT_W'(1) << shamt) - CNT_W'(1);
        tick     = (st_q.cnt == last_cnt);
        tick2    = tick || (st_q.cnt == half_cnt);
        st_d     = st_q;
        if (tick) begin
            // period boundary: the only place a new rate is taken
            st_d.cnt = '0;
            st_d.div = sel_div;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: enable pulses are isolated single cycles
    a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8: the divider in use only changes right after a boundary
    a_r8_div_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.div));

    // R7: the companion enable coincides with every main pulse
    a_r7_companion_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> tick2);

endmodule

// File: rtl/slowgo_prescaler.sv
module slowgo_prescaler
    import slowgo_pkg::*;
#(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    output logic       pre_en
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d.cnt = pre_q.cnt + PRE_W'(1);
        pre_en    = (mode == SPMODE_DIVIDE) ? (&pre_q.cnt) : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R9: pass-through modes keep the enable high
    a_r9_bypass_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SPMODE_DIVIDE) |-> pre_en);

    // R9: in divide mode two pulses are never adjacent
    a_r9_divide_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SPMODE_DIVIDE && pre_en) |=> (mode != SPMODE_DIVIDE || !pre_en));

endmodule

// File: rtl/slowgo_clkgen.sv
module slowgo_clkgen
    import slowgo_pkg::*;
#(
    parameter int DIV_W = 3,
    parameter int LVL_W = 3,
    parameter int PRE_W = 7
) (
    input  logic             clk_base,
    input  logic             rst_n,
    input  logic             src_ctl,
    input  logic [DIV_W-1:0] div_low,
    input  logic [DIV_W-1:0] div_high,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] irq_mask,
    input  logic             cp_req_en,
    input  logic             cp_busy,
    input  logic [1:0]       spclk_mode,
    output logic             gclk_en,
    output logic             gclk2_en,
    output logic             spclk_en
);

    rate_src_e        rate_src;
    logic [DIV_W-1:0] sel_div;

    slowgo_rate_sel #(
        .DIV_W(DIV_W),
        .LVL_W(LVL_W)
    ) u_sel (
        .src_ctl  (src_ctl),
        .div_low  (div_low),
        .div_high (div_high),
        .irq_level(irq_level),
        .irq_mask (irq_mask),
        .cp_req_en(cp_req_en),
        .cp_busy  (cp_busy),
        .rate_src (rate_src),
        .sel_div  (sel_div)
    );

    slowgo_period_ctr #(
        .DIV_W(DIV_W)
    ) u_ctr (
        .clk    (clk_base),
        .rst_n  (rst_n),
        .sel_div(sel_div),
        .tick   (gclk_en),
        .tick2  (gclk2_en)
    );

    slowgo_prescaler #(
        .PRE_W(PRE_W)
    ) u_pre (
        .clk   (clk_base),
        .rst_n (rst_n),
        .mode  (spclk_mode),
        .pre_en(spclk_en)
    );

    // R2: with low power disallowed the normal source is chosen
    a_r2_forced_normal: assert property (@(posedge clk_base) disable iff (!rst_n)
        !src_ctl |-> (rate_src == SRC_NORMAL && sel_div == '0));

    // R5: a lone request-enable never selects the high source
    a_r5_cp_needs_both: assert property (@(posedge clk_base) disable iff (!rst_n)
        (src_ctl && cp_req_en && !cp_busy && !(irq_level > irq_mask)) |-> (rate_src == SRC_LOW));

endmodule

// File: tb/test_slowgo_clkgen.sv
module test_slowgo_clkgen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       src_ctl;
    logic [2:0] div_low, div_high, irq_level, irq_mask;
    logic       cp_req_en, cp_busy;
    logic [1:0] spclk_mode;
    logic       gclk_en, gclk2_en, spclk_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    slowgo_clkgen i_slowgo_clkgen (
        .clk_base (clk),
        .rst_n    (rst_n),
        .src_ctl  (src_ctl),
        .div_low  (div_low),
        .div_high (div_high),
        .irq_level(irq_level),
        .irq_mask (irq_mask),
        .cp_req_en(cp_req_en),
        .cp_busy  (cp_busy),
        .spclk_mode(spclk_mode),
        .gclk_en  (gclk_en),
        .gclk2_en (gclk2_en),
        .spclk_en (spclk_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // From one gclk_en pulse to the next: period, companion count, first companion position
    task automatic measure(output int p, output int n2, output int mid);
        do @(negedge clk); while (!gclk_en);
        p = 0; n2 = 0; mid = 0;
        do begin
            @(negedge clk);
            p++;
            if (gclk2_en) begin
                n2++;
                if (mid == 0) mid = p;
            end
        end while (!gclk_en);
    endtask

    // Discard one period so that the current selection is in force
    task automatic settled(output int p, output int n2, output int mid);
        measure(p, n2, mid);
        measure(p, n2, mid);
    endtask

    task automatic t_reset;
        int p, n2, mid;
        rst_n = 1'b0; src_ctl = 1'b0; div_low = 3'd0; div_high = 3'd0;
        irq_level = 3'd0; irq_mask = 3'd0; cp_req_en = 1'b0; cp_busy = 1'b0;
        spclk_mode = 2'b01;
        repeat (4) @(negedge clk);
        chk(gclk_en == 1'b0, "R1 gclk_en in reset", int'(gclk_en), 0);
        chk(spclk_en == 1'b0, "R1 spclk_en in reset", int'(spclk_en), 0);
        rst_n = 1'b1;
        measure(p, n2, mid);
        chk(p == 2, "R1 period after reset", p, 2);
        chk(p >= 2, "R10 no consecutive pulses", p, 2);
    endtask

    task automatic t_forced_normal;
        int p, n2, mid;
        src_ctl = 1'b0; div_low = 3'd3; div_high = 3'd2;
        settled(p, n2, mid);
        chk(p == 2, "R2 src_ctl=0 quiet", p, 2);
        irq_level = 3'd6; irq_mask = 3'd1;
        settled(p, n2, mid);
        chk(p == 2, "R2 src_ctl=0 with interrupt", p, 2);
        irq_level = 3'd0;
    endtask

    task automatic t_low_rate;
        int p, n2, mid;
        src_ctl = 1'b1; irq_level = 3'd0; irq_mask = 3'd3;
        cp_req_en = 1'b0; cp_busy = 1'b0;
        for (int n = 1; n <= 3; n++) begin
            div_low = 3'(n);
            settled(p, n2, mid);
            chk(p == (2 << (2 * n)), "R3 low period", p, 2 << (2 * n));
            chk(n2 == 2, "R7 companion count", n2, 2);
            chk(mid == (1 << (2 * n)), "R7 companion midpoint", mid, 1 << (2 * n));
        end
    endtask

    task automatic t_interrupt;
        int p, n2, mid;
        src_ctl = 1'b1; div_low = 3'd3; div_high = 3'd1;
        irq_level = 3'd5; irq_mask = 3'd4;
        settled(p, n2, mid);
        chk(p == 8, "R4 level above mask", p, 8);
        irq_level = 3'd4;
        settled(p, n2, mid);
        chk(p == 128, "R4 level equal mask", p, 128);
        irq_level = 3'd7; irq_mask = 3'd0;
        settled(p, n2, mid);
        chk(p == 8, "R4 level 7 over mask 0", p, 8);
        irq_level = 3'd0; irq_mask = 3'd3;
    endtask

    task automatic t_coproc;
        int p, n2, mid;
        src_ctl = 1'b1; div_low = 3'd3; div_high = 3'd1;
        cp_req_en = 1'b1; cp_busy = 1'b1;
        settled(p, n2, mid);
        chk(p == 8, "R5 enabled and busy", p, 8);
        cp_req_en = 1'b0;
        settled(p, n2, mid);
        chk(p == 128, "R5 busy without enable", p, 128);
        cp_req_en = 1'b1; cp_busy = 1'b0;
        settled(p, n2, mid);
        chk(p == 128, "R5 enable while idle", p, 128);
        cp_req_en = 1'b0;
    endtask

    task automatic t_high_zero;
        int p, n2, mid;
        src_ctl = 1'b1; div_low = 3'd2; div_high = 3'd0;
        irq_level = 3'd2; irq_mask = 3'd1;
        settled(p, n2, mid);
        chk(p == 2, "R6 zero high field", p, 2);
        chk(n2 == 2, "R7 companion at normal rate", n2, 2);
        irq_level = 3'd0;
    endtask

    task automatic t_boundary;
        int p, n2, mid, cnt;
        src_ctl = 1'b1; div_low = 3'd2;
        settled(p, n2, mid);
        chk(p == 32, "R8 low period before change", p, 32);
        cnt = 0;
        repeat (5) begin
            @(negedge clk);
            cnt++;
        end
        src_ctl = 1'b0;
        while (!gclk_en) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 32, "R8 period in progress kept", cnt, 32);
        measure(p, n2, mid);
        chk(p == 2, "R8 new rate after boundary", p, 2);
    endtask

    task automatic t_spclk;
        int gap, highs;
        spclk_mode = 2'b01;
        do @(negedge clk); while (!spclk_en);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!spclk_en);
        chk(gap == 128, "R9 divide mode spacing", gap, 128);
        spclk_mode = 2'b11;
        highs = 0;
        repeat (10) begin
            @(negedge clk);
            if (spclk_en) highs++;
        end
        chk(highs == 10, "R9 mode 11 pass-through", highs, 10);
        spclk_mode = 2'b00;
        highs = 0;
        repeat (10) begin
            @(negedge clk);
            if (spclk_en) highs++;
        end
        chk(highs == 10, "R9 mode 00 pass-through", highs, 10);
    endtask

    initial begin
        t_reset;
        t_forced_normal;
        t_low_rate;
        t_interrupt;
        t_coproc;
        t_high_zero;
        t_boundary;
        t_spclk;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1_500_000ns;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule